// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block turns a pixel clock into raster timing. Software programs the number of clocks per line and the length of a field, counted in half-lines. The block then keeps a pixel counter and a line counter, and alternates between a top field and a bottom field. From those counters it derives four outputs:

- an active-video window flag, with separate window corners for each field;
- four independent sync sets, each with a horizontal pulse and a vertical pulse. The horizontal pulse may wrap past the end of a line. The vertical pulse changes state at a programmed pixel inside its start and stop lines;
- an interrupt that marks the start of each field;
- a soft restart.

The block runs as the timing master or as a slave. In slave mode it is locked to an external sync input.

All settings sit behind a 32-bit word-addressed register port. Writes to it take one clock, and reads from it are combinational. Timing words are held in a programmed copy. That copy moves into the working copy only at the start of a top field, on a restart, or on a slave resync. A field in progress therefore always runs on one consistent set of values.

Top module: `vid_timing_gen`

## Requirements
- R1: While reset is held, every sync output, the active flag and irq are low, and the mode, status and mask words read as 0. After reset the counters start at pixel 0, line 1, top field, and every timing word is 0.
- R2: The timing word at index 8 gives the line length L in bits [15:0]. The pixel counter runs 0 to L-1 and then returns to 0 and steps the line.
- R3: The timing word at index 9 gives the field length in half-lines in bits [15:0]. A field holds that value shifted right by one (bit 0 ignored) lines, numbered from 1. Fields alternate top, bottom, top.
- R4: The active flag is high when the line lies between the line fields and the pixel lies between the pixel fields of the current field's window pair, bounds included. Each window word packs the line in [31:16] and the pixel in [15:0]. Top start and stop are at words 10 and 11, bottom start and stop at words 12 and 13.
- R5: Set k uses words 14+5k to 18+5k, in the order: horizontal, top line span, bottom line span, top pixel pair, bottom pixel pair. Horizontal sync k is high from the pixel in bits [15:0] up to, but not including, the pixel in [31:16]. It wraps past the end of the line when the first value is larger. Equal values give no pulse.
- R6: Vertical sync k goes high one clock after the counters reach the span's start line ([15:0]) at the start pixel of the pixel pair ([15:0]). It goes low one clock after they reach the stop line ([31:16]) at the stop pixel ([31:16]). Assertion wins over deassertion, and the top or bottom words are used according to the current field.
- R7: Status bit 1 (top) or bit 0 (bottom) is set one clock after the counters sit at pixel 0, line 1 of that field. A set beats a clear in the same cycle.
- R8: Writing ones to word 3 clears status bits. Writing ones to word 4 sets mask bits and writing ones to word 5 clears them. Word 2 reads the status and word 4 reads the mask. irq is the OR of status AND mask.
- R9: A write with bit 0 set to word 1 puts the counters at pixel 0, line 1, top field on that clock edge. The same write drops every vertical sync and loads the working timing words.
- R10: Word 0 bit 0 selects master (0) or slave (1). In slave mode a rising edge seen on ext_sync puts the counters at pixel 0, line 1, top field on that edge, clears vertical syncs and loads the timing words. In master mode ext_sync has no effect.
- R11: Timing writes change the outputs only from the next top-field start, restart or resync onward.
- R12: Timing words read back their programmed value at once, and unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ext_sync | input | 1 | External sync used in slave mode |
| active | output | 1 | Active-video window flag |
| hsync | output | NUM_SETS | Horizontal pulse of each sync set |
| vsync | output | NUM_SETS | Vertical pulse of each sync set |
| irq | output | 1 | Field-start interrupt |

## Verification
A restart write or a slave resync moves the counters on the edge that samples it. The active flag and the horizontal syncs are decoded from the counters, so they follow in the same cycle. Vertical syncs and status bits are registered, so they appear one edge after the triggering position, and irq follows status and mask without extra delay. The bench keeps a cycle-accurate model that applies each edge's effects from the state before that edge. It samples all outputs 1 ns after every rising edge and compares them with the model, so each result is checked in the exact cycle it is due.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned POS_W  = 16;
    localparam int unsigned IRQ_W  = 2;

    // control word indices
    localparam logic [ADDR_W-1:0] A_MODE     = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_RESTART  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_STAT     = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_STAT_CLR = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_MASK_SET = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_MASK_CLR = ADDR_W'(5);
    localparam logic [ADDR_W-1:0] A_TIM_BASE = ADDR_W'(8);

    // offsets inside the timing block
    localparam int unsigned T_LINE_LEN  = 0;
    localparam int unsigned T_FIELD_HL  = 1;
    localparam int unsigned T_WIN_TOP_S = 2;
    localparam int unsigned T_WIN_TOP_E = 3;
    localparam int unsigned T_WIN_BOT_S = 4;
    localparam int unsigned T_WIN_BOT_E = 5;
    localparam int unsigned T_SET0      = 6;
    localparam int unsigned SET_STRIDE  = 5;
    localparam int unsigned S_HORZ      = 0;
    localparam int unsigned S_VL_TOP    = 1;
    localparam int unsigned S_VL_BOT    = 2;
    localparam int unsigned S_VP_TOP    = 3;
    localparam int unsigned S_VP_BOT    = 4;

    localparam int unsigned IRQ_BOT = 0;
    localparam int unsigned IRQ_TOP = 1;

    typedef enum logic {FLD_TOP = 1'b0, FLD_BOT = 1'b1} field_e;

    typedef struct packed {
        logic [POS_W-1:0] line;
        logic [POS_W-1:0] pix;
    } rpos_t;

    typedef logic [DATA_W-1:0] word_t;

    function automatic int unsigned tim_words(input int unsigned sets);
        return T_SET0 + SET_STRIDE * sets;
    endfunction

    // half-open span [on_pos, off_pos) that may wrap past the line end
    function automatic logic in_wrap(input logic [POS_W-1:0] p,
                                     input logic [POS_W-1:0] on_pos,
                                     input logic [POS_W-1:0] off_pos);
        if (on_pos == off_pos) return 1'b0;
        if (on_pos < off_pos)  return (p >= on_pos) && (p < off_pos);
        return (p >= on_pos) || (p < off_pos);
    endfunction

    function automatic logic in_range(input logic [POS_W-1:0] p,
                                      input logic [POS_W-1:0] lo,
                                      input logic [POS_W-1:0] hi);
        return (p >= lo) && (p <= hi);
    endfunction
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs import vtg_pkg::*; #(
    parameter int unsigned TW = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  word_t             reg_wdata,
    output word_t             reg_rdata,
    input  logic              field_start,
    input  field_e            field,
    input  logic              load_live,
    output logic              slave_mode,
    output logic              restart,
    output logic              irq,
    output word_t             live [TW]
);
    localparam int unsigned TIW = $clog2(TW);

    word_t             prog [TW];
    logic [IRQ_W-1:0]  stat_q, mask_q, stat_set, stat_clr;
    logic [ADDR_W-1:0] tidx;
    logic [TIW-1:0]    tsel;
    logic              in_tim;

    assign tidx    = reg_addr - A_TIM_BASE;
    assign tsel    = tidx[TIW-1:0];
    assign in_tim  = (reg_addr >= A_TIM_BASE) && (tidx < ADDR_W'(TW));
    assign restart = reg_we && (reg_addr == A_RESTART) && reg_wdata[0];

    always_comb begin
        stat_set          = '0;
        stat_set[IRQ_TOP] = field_start && (field == FLD_TOP);
        stat_set[IRQ_BOT] = field_start && (field == FLD_BOT);
        stat_clr = (reg_we && reg_addr == A_STAT_CLR) ? reg_wdata[IRQ_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slave_mode <= 1'b0;
            stat_q     <= '0;
            mask_q     <= '0;
            for (int i = 0; i < int'(TW); i++) begin
                prog[i] <= '0;
                live[i] <= '0;
            end
        end else begin
            stat_q <= (stat_q & ~stat_clr) | stat_set;
            if (reg_we && reg_addr == A_MODE)     slave_mode <= reg_wdata[0];
            if (reg_we && reg_addr == A_MASK_SET) mask_q <= mask_q | reg_wdata[IRQ_W-1:0];
            if (reg_we && reg_addr == A_MASK_CLR) mask_q <= mask_q & ~reg_wdata[IRQ_W-1:0];
            if (load_live)
                for (int i = 0; i < int'(TW); i++) live[i] <= prog[i];
            if (reg_we && in_tim) prog[tsel] <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (in_tim) reg_rdata = prog[tsel];
        else begin
            case (reg_addr)
                A_MODE:     reg_rdata = word_t'(slave_mode);
                A_STAT:     reg_rdata = word_t'(stat_q);
                A_MASK_SET: reg_rdata = word_t'(mask_q);
                default:    reg_rdata = '0;
            endcase
        end
    end

    assign irq = |(stat_q & mask_q);

    assert_top_status_R7: assert property (@(posedge clk) disable iff (rst)
        (field_start && field == FLD_TOP) |=> stat_q[IRQ_TOP]);
    assert_bot_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == A_STAT_CLR && reg_wdata[IRQ_BOT]
         && !(field_start && field == FLD_BOT)) |=> !stat_q[IRQ_BOT]);
    assert_mask_set_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == A_MASK_SET)
        |=> ((mask_q & $past(reg_wdata[IRQ_W-1:0])) == $past(reg_wdata[IRQ_W-1:0])));
    assert_live_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !load_live |=> $stable(live[T_LINE_LEN]));
endmodule

// File: rtl/vtg_raster.sv
module vtg_raster import vtg_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             slave_mode,
    input  logic             ext_sync,
    input  logic [POS_W-1:0] line_len,
    input  logic [POS_W-1:0] field_hl,
    output rpos_t            pos,
    output field_e           field,
    output logic             field_start,
    output logic             load_live,
    output logic             resync
);
    logic             sync_q, sync_rise, last_pix, last_line;
    logic [POS_W-1:0] lines_per_field;
    logic [POS_W:0]   pix_inc;
    logic             unused_hl0;

    assign unused_hl0      = field_hl[0];
    assign lines_per_field = {1'b0, field_hl[POS_W-1:1]};
    assign pix_inc         = {1'b0, pos.pix} + (POS_W+1)'(1);
    assign last_pix        = pix_inc >= {1'b0, line_len};
    assign last_line       = pos.line >= lines_per_field;
    assign sync_rise       = slave_mode && ext_sync && !sync_q;
    assign resync          = restart || sync_rise;
    assign field_start     = (pos.pix == '0) && (pos.line == POS_W'(1));
    assign load_live       = resync || (last_pix && last_line && field == FLD_BOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos    <= '{line: POS_W'(1), pix: '0};
            field  <= FLD_TOP;
            sync_q <= 1'b0;
        end else begin
            sync_q <= ext_sync;
            if (resync) begin
                pos   <= '{line: POS_W'(1), pix: '0};
                field <= FLD_TOP;
            end else if (last_pix) begin
                pos.pix <= '0;
                if (last_line) begin
                    pos.line <= POS_W'(1);
                    field    <= (field == FLD_TOP) ? FLD_BOT : FLD_TOP;
                end else begin
                    pos.line <= pos.line + POS_W'(1);
                end
            end else begin
                pos.pix <= pos.pix + POS_W'(1);
            end
        end
    end

    assert_pix_in_line_R2: assert property (@(posedge clk) disable iff (rst)
        (line_len != '0) |-> (pos.pix < line_len));
    assert_line_in_field_R3: assert property (@(posedge clk) disable iff (rst)
        (lines_per_field != '0) |-> (pos.line >= POS_W'(1) && pos.line <= lines_per_field));
    assert_restart_home_R9: assert property (@(posedge clk) disable iff (rst)
        restart |=> (pos.pix == '0 && pos.line == POS_W'(1) && field == FLD_TOP));
    assert_slave_lock_R10: assert property (@(posedge clk) disable iff (rst)
        sync_rise |=> (pos.pix == '0 && pos.line == POS_W'(1) && field == FLD_TOP));
endmodule

// File: rtl/vtg_sync_set.sv
module vtg_sync_set import vtg_pkg::*; (
    input  logic   clk,
    input  logic   rst,
    input  logic   resync,
    input  rpos_t  pos,
    input  field_e field,
    input  word_t  horz,
    input  word_t  vl_top,
    input  word_t  vl_bot,
    input  word_t  vp_top,
    input  word_t  vp_bot,
    output logic   hsync,
    output logic   vsync
);
    word_t vl, vp;
    logic  v_on, v_off;

    assign vl    = (field == FLD_TOP) ? vl_top : vl_bot;
    assign vp    = (field == FLD_TOP) ? vp_top : vp_bot;
    assign hsync = in_wrap(pos.pix, horz[POS_W-1:0], horz[2*POS_W-1:POS_W]);
    assign v_on  = (pos.line == vl[POS_W-1:0]) && (pos.pix == vp[POS_W-1:0]);
    assign v_off = (pos.line == vl[2*POS_W-1:POS_W]) && (pos.pix == vp[2*POS_W-1:POS_W]);

    always_ff @(posedge clk) begin
        if (rst || resync) vsync <= 1'b0;
        else if (v_on)     vsync <= 1'b1;
        else if (v_off)    vsync <= 1'b0;
    end

    assert_vs_rise_R6: assert property (@(posedge clk) disable iff (rst)
        (v_on && !resync) |=> vsync);
    assert_vs_fall_R6: assert property (@(posedge clk) disable iff (rst)
        (v_off && !v_on && !resync) |=> !vsync);
    assert_vs_resync_R9: assert property (@(posedge clk) disable iff (rst)
        resync |=> !vsync);
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen import vtg_pkg::*; #(
    parameter int unsigned NUM_SETS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                ext_sync,
    output logic                active,
    output logic [NUM_SETS-1:0] hsync,
    output logic [NUM_SETS-1:0] vsync,
    output logic                irq
);
    localparam int unsigned TW = tim_words(NUM_SETS);

    word_t  live [TW];
    rpos_t  pos;
    field_e field;
    logic   field_start, load_live, resync, restart, slave_mode;
    word_t  win_s, win_e;
    logic   unused_hi;

    assign unused_hi = ^{live[T_LINE_LEN][DATA_W-1:POS_W], live[T_FIELD_HL][DATA_W-1:POS_W]};

    vtg_regs #(.TW(TW)) u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .field_start(field_start), .field(field), .load_live(load_live),
        .slave_mode(slave_mode), .restart(restart), .irq(irq), .live(live)
    );

    vtg_raster u_raster (
        .clk(clk), .rst(rst), .restart(restart), .slave_mode(slave_mode),
        .ext_sync(ext_sync),
        .line_len(live[T_LINE_LEN][POS_W-1:0]),
        .field_hl(live[T_FIELD_HL][POS_W-1:0]),
        .pos(pos), .field(field), .field_start(field_start),
        .load_live(load_live), .resync(resync)
    );

    assign win_s  = (field == FLD_TOP) ? live[T_WIN_TOP_S] : live[T_WIN_BOT_S];
    assign win_e  = (field == FLD_TOP) ? live[T_WIN_TOP_E] : live[T_WIN_BOT_E];
    assign active = in_range(pos.line, win_s[2*POS_W-1:POS_W], win_e[2*POS_W-1:POS_W])
                 && in_range(pos.pix,  win_s[POS_W-1:0],       win_e[POS_W-1:0]);

    for (genvar k = 0; k < NUM_SETS; k++) begin : g_set
        vtg_sync_set u_set (
            .clk(clk), .rst(rst), .resync(resync), .pos(pos), .field(field),
            .horz  (live[T_SET0 + SET_STRIDE*k + S_HORZ]),
            .vl_top(live[T_SET0 + SET_STRIDE*k + S_VL_TOP]),
            .vl_bot(live[T_SET0 + SET_STRIDE*k + S_VL_BOT]),
            .vp_top(live[T_SET0 + SET_STRIDE*k + S_VP_TOP]),
            .vp_bot(live[T_SET0 + SET_STRIDE*k + S_VP_BOT]),
            .hsync(hsync[k]), .vsync(vsync[k])
        );
    end
endmodule

// File: tb/vid_timing_gen_tb.sv
module vid_timing_gen_tb;
    localparam int NS  = 4;
    localparam int TWB = 6 + 5*NS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ext_sync = 1'b0;
    logic        active, irq;
    logic [NS-1:0] hsync, vsync;

    int n_checks = 0;
    int n_fail   = 0;
    string cur_req = "R1";

    // reference model state
    logic [31:0] m_prog [TWB];
    logic [31:0] m_live [TWB];
    logic        m_slave, m_fld, m_es_q;
    logic [1:0]  m_stat, m_mask;
    logic [NS-1:0] m_vs;
    int          m_pix, m_line;

    always #5 clk = ~clk;

    vid_timing_gen #(.NUM_SETS(NS)) u_dut (
        .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .ext_sync(ext_sync), .active(active),
        .hsync(hsync), .vsync(vsync), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic wrap_span(input int p, input int on_p, input int off_p);
        if (on_p == off_p) return 1'b0;
        if (on_p < off_p)  return (p >= on_p) && (p < off_p);
        return (p >= on_p) || (p < off_p);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < TWB; i++) begin m_prog[i] = '0; m_live[i] = '0; end
        m_slave = 0; m_fld = 0; m_es_q = 0; m_stat = 0; m_mask = 0; m_vs = 0;
        m_pix = 0; m_line = 1;
    endtask

    // effects of one rising edge, from the state before it
    task automatic model_edge();
        int L, lpf, np, nl, b;
        logic nf, rise, rs, lp, ll, ld;
        logic [1:0] set_b, clr_b;
        logic [NS-1:0] nvs;
        logic [31:0] vl, vp;
        rise = m_slave && ext_sync && !m_es_q;
        rs   = (we && addr == 8'd1 && wdata[0]) || rise;
        L    = int'(m_live[0][15:0]);
        lpf  = int'(m_live[1][15:1]);
        lp   = (m_pix + 1) >= L;
        ll   = m_line >= lpf;
        for (int k = 0; k < NS; k++) begin
            b  = 6 + 5*k;
            vl = m_fld ? m_live[b+2] : m_live[b+1];
            vp = m_fld ? m_live[b+4] : m_live[b+3];
            if (rs) nvs[k] = 1'b0;
            else if (m_line == int'(vl[15:0]) && m_pix == int'(vp[15:0])) nvs[k] = 1'b1;
            else if (m_line == int'(vl[31:16]) && m_pix == int'(vp[31:16])) nvs[k] = 1'b0;
            else nvs[k] = m_vs[k];
        end
        set_b = 2'b00;
        if (m_pix == 0 && m_line == 1) set_b = m_fld ? 2'b01 : 2'b10;
        clr_b = (we && addr == 8'd3) ? wdata[1:0] : 2'b00;
        ld = rs || (lp && ll && m_fld);
        if (rs) begin np = 0; nl = 1; nf = 0; end
        else if (lp) begin
            np = 0;
            if (ll) begin nl = 1; nf = !m_fld; end
            else begin nl = m_line + 1; nf = m_fld; end
        end else begin np = m_pix + 1; nl = m_line; nf = m_fld; end
        if (ld) for (int i = 0; i < TWB; i++) m_live[i] = m_prog[i];
        if (we) begin
            if (addr == 8'd0) m_slave = wdata[0];
            if (addr == 8'd4) m_mask = m_mask | wdata[1:0];
            if (addr == 8'd5) m_mask = m_mask & ~wdata[1:0];
            if (addr >= 8'd8 && int'(addr) < 8 + TWB) m_prog[int'(addr) - 8] = wdata;
        end
        m_stat = (m_stat & ~clr_b) | set_b;
        m_vs = nvs; m_pix = np; m_line = nl; m_fld = nf; m_es_q = ext_sync;
    endtask

    task automatic compare();
        logic [NS-1:0] ehs;
        logic [31:0] ws, we_w, h;
        logic eact;
        for (int k = 0; k < NS; k++) begin
            h = m_live[6 + 5*k];
            ehs[k] = wrap_span(m_pix, int'(h[15:0]), int'(h[31:16]));
        end
        ws   = m_fld ? m_live[4] : m_live[2];
        we_w = m_fld ? m_live[5] : m_live[3];
        eact = (m_line >= int'(ws[31:16])) && (m_line <= int'(we_w[31:16]))
            && (m_pix >= int'(ws[15:0])) && (m_pix <= int'(we_w[15:0]));
        check({cur_req, " R5 hsync"}, 32'(hsync), 32'(ehs));
        check({cur_req, " R6 vsync"}, 32'(vsync), 32'(m_vs));
        check({cur_req, " R4 active"}, 32'(active), 32'(eact));
        check({cur_req, " R8 irq"}, 32'(irq), 32'(|(m_stat & m_mask)));
    endtask

    task automatic cyc();
        model_edge();
        @(posedge clk);
        #1;
        compare();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        cyc();
        we = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic read_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
        addr = '0;
    endtask

    task automatic t_reset();
        cur_req = "R1";
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R1 hsync in reset", 32'(hsync), 0);
        check("R1 vsync in reset", 32'(vsync), 0);
        check("R1 active in reset", 32'(active), 0);
        check("R1 irq in reset", 32'(irq), 0);
        read_check("R1 status word", 8'd2, 0);
        read_check("R1 mask word", 8'd4, 0);
        read_check("R1 mode word", 8'd0, 0);
        rst = 1'b0;
        run(4);
    endtask

    task automatic t_regs();
        cur_req = "R12";
        write_reg(8'd20, 32'h1234_5678);
        read_check("R12 timing readback", 8'd20, 32'h1234_5678);
        write_reg(8'd20, 32'h0);
        read_check("R12 unmapped word 6", 8'd6, 0);
        read_check("R12 restart word reads 0", 8'd1, 0);
        read_check("R12 word past timing block", 8'(8 + TWB), 0);
        run(3);
    endtask

    task automatic t_config();
        logic [31:0] cfg [TWB];
        cur_req = "R2 R3";
        for (int i = 0; i < TWB; i++) cfg[i] = '0;
        cfg[0]  = 32'd10;                // line length
        cfg[1]  = 32'd9;                 // odd half-lines: 4 lines per field
        cfg[2]  = {16'd2, 16'd3};  cfg[3]  = {16'd3, 16'd6};
        cfg[4]  = {16'd1, 16'd0};  cfg[5]  = {16'd1, 16'd9};
        cfg[6]  = {16'd1, 16'd0};  cfg[7]  = {16'd2, 16'd1};
        cfg[8]  = {16'd4, 16'd3};  cfg[9]  = {16'd0, 16'd0};
        cfg[10] = {16'd2, 16'd5};
        cfg[11] = {16'd2, 16'd8};        // wraps past line end
        cfg[12] = {16'd2, 16'd2};  cfg[13] = {16'd1, 16'd1};
        cfg[14] = {16'd7, 16'd2};  cfg[15] = {16'd0, 16'd9};
        cfg[16] = {16'd3, 16'd3};        // equal edges: no pulse
        cfg[21] = {16'd10, 16'd5}; cfg[22] = {16'd1, 16'd4};
        cfg[24] = {16'd3, 16'd3};
        for (int i = 0; i < TWB; i++) write_reg(8'(8 + i), cfg[i]);
        cur_req = "R9";
        write_reg(8'd1, 32'd1);
        cur_req = "R2 R3";
        run(170);
        cur_req = "R9";
        run(13);
        write_reg(8'd1, 32'd1);          // restart mid-field
        run(30);
    endtask

    task automatic t_irq();
        cur_req = "R7";
        write_reg(8'd4, 32'd3);
        read_check("R8 mask readback", 8'd4, 32'd3);
        run(90);
        write_reg(8'd3, 32'd3);
        read_check("R8 status after clear", 8'd2, 32'(m_stat));
        while (!(m_pix == 0 && m_line == 1 && !m_fld)) cyc();
        write_reg(8'd3, 32'd2);          // clear collides with top set
        read_check("R7 set beats clear", 8'd2, 32'(m_stat));
        check("R7 top bit survives", 32'(m_stat[1]), 1);
        cur_req = "R8";
        write_reg(8'd5, 32'd2);
        read_check("R8 mask after clear", 8'd4, 32'd1);
        run(90);
    endtask

    task automatic t_defer();
        cur_req = "R11";
        while (!(m_line == 2 && !m_fld)) cyc();
        write_reg(8'd8, 32'd12);
        write_reg(8'd11, {16'd4, 16'd11});
        read_check("R11 programmed value visible", 8'd8, 32'd12);
        run(120);
    endtask

    task automatic t_slave();
        cur_req = "R10";
        write_reg(8'd0, 32'd1);
        read_check("R10 mode readback", 8'd0, 32'd1);
        run(17);
        ext_sync = 1'b1;
        run(3);
        ext_sync = 1'b0;
        run(25);
        write_reg(8'd0, 32'd0);
        run(7);
        ext_sync = 1'b1;                 // ignored in master mode
        run(3);
        ext_sync = 1'b0;
        run(40);
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_regs();
        t_config();
        t_irq();
        t_defer();
        t_slave();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule